// File: doc/BRIEF.md
# Dual-Channel Cascaded Serial Result Shifter

This block is the serial output stage of a two-channel sampling converter. Each channel delivers an 18-bit result in parallel. A convert strobe, taken on a rising bit-clock edge, moves the held pair of results into two shift lanes and captures the newly presented pair for the next frame. So every frame carries the results presented at the previous convert. Between strobes the lanes advance by one bit on every rising edge, MSB first. Behind the data, each lane takes in a registered copy of its tag serial input, so a tag stream follows the data on the line.

A mode input selects how output A is formed. In split mode (cascade = 0), output A sends channel A's 18-bit result and then its own tag stream. Output B does the same for channel B. In chained mode (cascade = 1), output A sends the top 16 bits of channel A. It then sends all 18 bits of channel B, fed from the channel B lane through a 16-stage extension. After that it carries the channel B tag stream, delayed by 35 bit clocks. Output B behaves the same in both modes. The mode is applied to output A on every edge, so a change takes effect at once.

Top module: `dual_result_serializer`

## Requirements
- R1: While rst is high on a rising edge, out_a and out_b are 0 after that edge. The held results are cleared, so the data bits of the first frame after reset are all zero.
- R2: A convert strobe sampled at edge k loads the held pair. The MSB (bit 17) of the loaded result appears on each output after edge k+1.
- R3: The data sent after a convert at edge k are the res_a/res_b values sampled at the previous convert, or zero if there was none since reset. Bit 17-(p-1) appears after edge k+p, for p from 1 to 18.
- R4: In either mode, once its 18 data bits are sent, out_b sends the tag_b value sampled at edge e-19 after edge e.
- R5: In split mode, out_a sends channel A's 18 data bits in the same way as R3. After them, out_a shows the tag_a value sampled at edge e-19 after edge e.
- R6: In chained mode, after a convert at edge k, out_a shows channel A bits 17 down to 2 after edges k+1 to k+16. It then shows channel B bits 17 down to 0 after edges k+17 to k+34.
- R7: In chained mode, after its 34 data bits, out_a shows the tag_b value sampled at edge e-35 after edge e.
- R8: Output B is the same in split and chained mode.
- R9: A convert strobe that comes before a frame is complete restarts both outputs with the new frame at the next edge.
- R10: The mode in force at edge e decides the out_a bit after edge e. Both paths keep running, so a mid-frame change picks up the other path at its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv | input | 1 | Convert strobe, one bit-clock wide |
| cascade | input | 1 | 1 = chained output A, 0 = split outputs |
| res_a | input | 18 | Channel A conversion result |
| res_b | input | 18 | Channel B conversion result |
| tag_a | input | 1 | Tag serial input for channel A |
| tag_b | input | 1 | Tag serial input for channel B |
| out_a | output | 1 | Serial output A (registered) |
| out_b | output | 1 | Serial output B (registered) |

## Verification
The bench builds the block with its default widths: 18-bit results and a 16-bit chained prefix. With these values the full 35-edge tag delay on output A and the 19-edge delay on both split paths are reached within one frame interval. Convert spacings of 9 to 45 edges cover frames that end well into the tag stream as well as frames cut short before their data bits are out. A mode toggled mid-frame and a reset in the middle of a run are also covered.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int DSR_RES_W  = 18;
  localparam int DSR_CASC_W = 16;
  localparam int DSR_NCH    = 2;

  typedef enum logic {
    LINK_SPLIT = 1'b0,
    LINK_CHAIN = 1'b1
  } link_mode_t;
endpackage

// File: rtl/dsr_result_hold.sv
module dsr_result_hold #(
  parameter int RES_W = 18,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [NCH-1:0][RES_W-1:0] res_in,
  output logic [NCH-1:0][RES_W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (capture) begin
      res_q <= res_in;
    end
  end
endmodule

// File: rtl/dsr_tag_sync.sv
module dsr_tag_sync #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tag_in,
  output logic [NCH-1:0] tag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q <= tag_in;
    end
  end
endmodule

// File: rtl/dsr_shift_lane.sv
module dsr_shift_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ser_in,
  output logic [W-1:0] lane_q,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
    end else if (load) begin
      lane_q <= load_val;
    end else begin
      lane_q <= {lane_q[W-2:0], ser_in};
    end
  end

  assign msb = lane_q[W-1];
endmodule

// File: rtl/dual_result_serializer.sv
module dual_result_serializer #(
  parameter int RES_W  = dsr_pkg::DSR_RES_W,
  parameter int CASC_W = dsr_pkg::DSR_CASC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv,
  input  logic             cascade,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             tag_a,
  input  logic             tag_b,
  output logic             out_a,
  output logic             out_b
);
  import dsr_pkg::*;

  localparam int NCH    = DSR_NCH;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int TOP    = RES_W - 1;
  localparam int DROP_W = RES_W - CASC_W;

  logic [NCH-1:0][RES_W-1:0] res_in;
  logic [NCH-1:0][RES_W-1:0] hold_q;
  logic [NCH-1:0][RES_W-1:0] lane_q;
  logic [NCH-1:0]            lane_msb;
  logic [NCH-1:0]            tag_in;
  logic [NCH-1:0]            tag_q;
  logic [CASC_W-1:0]         ext_q;
  logic                      ext_msb;
  link_mode_t                mode;

  assign res_in[CH_A] = res_a;
  assign res_in[CH_B] = res_b;
  assign tag_in[CH_A] = tag_a;
  assign tag_in[CH_B] = tag_b;
  assign mode         = link_mode_t'(cascade);

  dsr_result_hold #(.RES_W(RES_W), .NCH(NCH)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (conv),
    .res_in  (res_in),
    .res_q   (hold_q)
  );

  dsr_tag_sync #(.NCH(NCH)) u_tag (
    .clk    (clk),
    .rst    (rst),
    .tag_in (tag_in),
    .tag_q  (tag_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    dsr_shift_lane #(.W(RES_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (conv),
      .load_val (hold_q[ch]),
      .ser_in   (tag_q[ch]),
      .lane_q   (lane_q[ch]),
      .msb      (lane_msb[ch])
    );
  end

  // Chained prefix: top CASC_W bits of channel A, refilled from lane B's MSB.
  dsr_shift_lane #(.W(CASC_W)) u_ext (
    .clk      (clk),
    .rst      (rst),
    .load     (conv),
    .load_val (hold_q[CH_A][TOP -: CASC_W]),
    .ser_in   (lane_msb[CH_B]),
    .lane_q   (ext_q),
    .msb      (ext_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= (mode == LINK_CHAIN) ? ext_msb : lane_msb[CH_A];
      out_b <= lane_msb[CH_B];
    end
  end

  if (DROP_W < 0) begin : g_bad_width
    initial $error("CASC_W must not exceed RES_W");
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int RES_W = 18
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  conv,
  input logic                  cascade,
  input logic [RES_W-1:0]      res_a,
  input logic [RES_W-1:0]      res_b,
  input logic                  tag_b,
  input logic                  out_a,
  input logic                  out_b,
  input logic [1:0][RES_W-1:0] hold_q,
  input logic [1:0][RES_W-1:0] lane_q
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b));

  assert_hold_capture_R3: assert property (@(posedge clk) disable iff (rst)
    conv |=> (hold_q[0] == $past(res_a) && hold_q[1] == $past(res_b)));

  assert_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(conv, 2)) |-> (out_b == $past(hold_q[1][RES_W-1], 2)));

  assert_tag_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && !$past(conv)) |-> (lane_q[1][0] == $past(tag_b, 2)));

  assert_split_first_R5: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(conv, 2) && !$past(cascade)) |->
      (out_a == $past(hold_q[0][RES_W-1], 2)));

  assert_chain_first_R6: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(conv, 2) && $past(cascade)) |->
      (out_a == $past(hold_q[0][RES_W-1], 2)));
endmodule

bind dual_result_serializer dsr_checker #(.RES_W(RES_W)) u_dsr_checker (
  .clk     (clk),
  .rst     (rst),
  .conv    (conv),
  .cascade (cascade),
  .res_a   (res_a),
  .res_b   (res_b),
  .tag_b   (tag_b),
  .out_a   (out_a),
  .out_b   (out_b),
  .hold_q  (hold_q),
  .lane_q  (lane_q)
);

// File: tb/dual_result_serializer_bench.sv
module dual_result_serializer_bench;
  localparam int RW   = 18;
  localparam int CW   = 16;
  localparam int MAXE = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv = 1'b0;
  logic cascade = 1'b0;
  logic [RW-1:0] res_a = '0;
  logic [RW-1:0] res_b = '0;
  logic tag_a = 1'b0;
  logic tag_b = 1'b0;
  logic out_a, out_b;

  dual_result_serializer #(.RES_W(RW), .CASC_W(CW)) u_dual_result_serializer (
    .clk(clk), .rst(rst), .conv(conv), .cascade(cascade),
    .res_a(res_a), .res_b(res_b), .tag_a(tag_a), .tag_b(tag_b),
    .out_a(out_a), .out_b(out_b)
  );

  always #10 clk = ~clk;

  bit tag_a_h [MAXE];
  bit tag_b_h [MAXE];
  int e = 0;
  int lastk = 0;
  int p;
  logic [RW-1:0] fr_a = '0, fr_b = '0, hd_a = '0, hd_b = '0;
  bit exp_a, exp_b;
  string req_a = "R1", req_b = "R1", phase = "reset";
  bit pending = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model: evaluates the expected outputs for edge e before updating state.
  always @(posedge clk) begin
    if (rst) begin
      exp_a = 0; exp_b = 0; req_a = "R1"; req_b = "R1";
      lastk = e; fr_a = '0; fr_b = '0; hd_a = '0; hd_b = '0;
      tag_a_h[e] = 0; tag_b_h[e] = 0;
    end else begin
      p = e - lastk;
      if (p <= RW) begin
        exp_b = fr_b[RW-p];
        req_b = (p == 1) ? "R2" : (cascade ? "R8" : "R3");
      end else begin
        exp_b = tag_b_h[e-RW-1];
        req_b = cascade ? "R8" : "R4";
      end
      if (cascade) begin
        if (p <= CW) begin
          exp_a = fr_a[RW-p]; req_a = "R6";
        end else if (p <= CW + RW) begin
          exp_a = fr_b[CW+RW-p]; req_a = "R6";
        end else begin
          exp_a = tag_b_h[e-CW-RW-1]; req_a = "R7";
        end
      end else begin
        if (p <= RW) exp_a = fr_a[RW-p];
        else exp_a = tag_a_h[e-RW-1];
        req_a = "R5";
      end
      if (conv) begin
        lastk = e; fr_a = hd_a; fr_b = hd_b; hd_a = res_a; hd_b = res_b;
      end
      tag_a_h[e] = tag_a; tag_b_h[e] = tag_b;
    end
    e = e + 1;
    pending = 1;
  end

  always @(negedge clk) begin
    if (pending && !done) begin
      checks = checks + 2;
      if (out_a !== exp_a) begin
        errors = errors + 1;
        $display("FAIL %s out_a edge %0d phase %s: actual %b expected %b", req_a, e-1, phase, out_a, exp_a);
      end
      if (out_b !== exp_b) begin
        errors = errors + 1;
        $display("FAIL %s out_b edge %0d phase %s: actual %b expected %b", req_b, e-1, phase, out_b, exp_b);
      end
    end
  end

  task automatic run_phase(input string name, input int cycles, input int period,
                           input bit mode, input bit toggle);
    phase = name;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      conv    = (i % period) == (period - 1);
      cascade = toggle ? ((i / 7) % 2 == 1) : mode;
      res_a   = RW'($urandom);
      res_b   = RW'($urandom);
      tag_a   = 1'($urandom);
      tag_b   = 1'($urandom);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    run_phase("R1 first frame zero", 30, 40, 1'b0, 1'b0);
    run_phase("split R4 R5", 400, 37, 1'b0, 1'b0);
    run_phase("chained R6 R7 R8", 400, 45, 1'b1, 1'b0);
    run_phase("R9 short interval", 200, 9, 1'b1, 1'b0);
    run_phase("R10 mode toggle", 300, 41, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1; conv = 1;
    repeat (3) @(negedge clk);
    rst = 0; conv = 0;
    run_phase("R1 mid-run reset", 200, 23, 1'b1, 1'b0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule